// File: doc/BRIEF.md
# Serial Register Access Master

This block is the host-side engine for a bit-banged style register port on a small companion logic device. A local request interface, made of a start strobe, a direction flag, an 8-bit register address and a 32-bit write value, becomes a serial exchange on three outputs: a serial clock, a data line toward the device and an active-low command strobe. A data line coming back from the device is sampled during reads. Each request ends with a one-cycle done pulse. For a read, the 32-bit result is presented on `rdata` at the same moment.

The two directions do not share a frame layout. A read shifts out only the address and then clocks 32 result bits back in. A write shifts out the value followed by the address and has no return phase. The direction is not carried by a framing select. It is carried by a single clock pulse taken while the command strobe is low, with the data line giving the direction. The serial bit rate comes from a half-period divider that is sampled at the start of every request. When reset is released, the block issues one read of the identification register at address 0xFF without being asked.

Top module: `serial_reg_master`

## Requirements
- R1: During reset and whenever the block is idle, `sck` is 0, `strobe_n` is 1 and `mosi` is 0, and once the power-up read has completed `busy` is 0 while idle.
- R2: Every shifted field leaves most significant bit first. `mosi` changes only while `sck` is low, so it is stable across each rising edge and each high phase.
- R3: A read (`wr`=0) sends exactly 8 address bits. It then sends one command clock pulse with `strobe_n`=0 and `mosi`=0, followed by exactly 32 further clock pulses with `strobe_n`=1.
- R4: A write (`wr`=1) sends exactly 40 bits, the 32-bit value first and then the 8-bit address. It then sends one command clock pulse with `strobe_n`=0 and `mosi`=1 and no further clock pulses. `rdata` keeps its previous value.
- R5: `strobe_n` goes low only while `sck` is low and returns high on the edge where `sck` falls. Exactly one rising `sck` edge occurs while it is low in each request.
- R6: In the read phase, `miso` is sampled at the end of each high phase of `sck` and shifted into the result from the least significant side. The first bit returned lands in bit 31, and the full word appears on `rdata` no later than the done pulse.
- R7: Each high phase and each low phase of `sck` lasts `half_div` system clocks, with a value of 0 treated as 1. The divider value is captured when a request starts.
- R8: `done` is high for exactly one system clock at the end of every request, and `busy` is low in the following cycle.
- R9: A `start` pulse presented while `busy` is high is ignored. No second exchange is produced and the device registers are not touched.
- R10: After reset is released, one read of address 0xFF is performed automatically. It ends with a done pulse and leaves the returned word on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System clocks per serial half period (0 acts as 1) |
| start | input | 1 | Request strobe, accepted when not busy |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Value to write |
| rdata | output | DATA_W | Last word read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in progress (including the power-up read) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data toward the device |
| strobe_n | output | 1 | Active-low command strobe |
| miso | input | 1 | Serial data from the device |

## Verification
The bench runs a behavioural device model that rebuilds each frame from the serial lines. It goes after the field order and bit order of both directions. A design that reversed the shift, or put the address before the value on writes, would store the value at the wrong register or return a rotated word. A read from a register holding 0x80000001 exposes an off-by-one sampling position, which would lose one end bit and duplicate the other. A divider of 0, a start pulse made during a transfer, and the unprompted power-up read are also targeted. A design that got these wrong would stall, start a second overlapping frame, or leave `rdata` at zero after reset.

// File: rtl/serial_reg_master.sv
module serial_reg_master #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              strobe_n,
  input  logic              miso
);
  localparam int SH_W  = DATA_W + ADDR_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_ADDR, S_CMD, S_IN, S_DONE} st_t;

  st_t               st;
  logic [DIV_W-1:0]  cnt, lim_q;
  logic              hi, wr_q, boot_q;
  logic [CNT_W-1:0]  left;
  logic [SH_W-1:0]   shreg;
  logic [DATA_W-1:0] rx;

  wire [DIV_W-1:0] lim_d    = (half_div == '0) ? DIV_W'(1) : half_div;
  wire             half_end = (cnt == lim_q - DIV_W'(1));
  wire             bit_end  = hi && half_end;
  wire             last     = (left == CNT_W'(1));
  wire             shifting = (st == S_DATA) || (st == S_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      hi     <= 1'b0;
      lim_q  <= DIV_W'(1);
      wr_q   <= 1'b0;
      boot_q <= 1'b1;
      left   <= '0;
      shreg  <= '0;
      rx     <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          hi  <= 1'b0;
          if (boot_q || start) begin
            lim_q  <= lim_d;
            boot_q <= 1'b0;
            if (!boot_q && wr) begin
              wr_q  <= 1'b1;
              st    <= S_DATA;
              left  <= CNT_W'(DATA_W);
              shreg <= {wdata, addr};
            end else begin
              wr_q  <= 1'b0;
              st    <= S_ADDR;
              left  <= CNT_W'(ADDR_W);
              shreg <= {(boot_q ? BOOT_ADDR : addr), {DATA_W{1'b0}}};
            end
          end
        end
        S_DONE: st <= S_IDLE;
        default: begin
          if (!half_end) cnt <= cnt + DIV_W'(1);
          else begin
            cnt <= '0;
            hi  <= !hi;
          end
          if (bit_end) begin
            left <= left - CNT_W'(1);
            if (shifting) shreg <= {shreg[SH_W-2:0], 1'b0};
            if (st == S_IN) rx <= {rx[DATA_W-2:0], miso};
            if (last) begin
              case (st)
                S_DATA: begin
                  st   <= S_ADDR;
                  left <= CNT_W'(ADDR_W);
                end
                S_ADDR: begin
                  st   <= S_CMD;
                  left <= CNT_W'(1);
                end
                S_CMD: begin
                  if (wr_q) st <= S_DONE;
                  else begin
                    st   <= S_IN;
                    left <= CNT_W'(DATA_W);
                  end
                end
                S_IN: begin
                  st    <= S_DONE;
                  rdata <= {rx[DATA_W-2:0], miso};
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign sck      = hi;
  assign strobe_n = (st != S_CMD);
  assign mosi     = shifting ? shreg[SH_W-1] : ((st == S_CMD) && wr_q);
  assign done     = (st == S_DONE);
  assign busy     = (st != S_IDLE) || boot_q;
endmodule

// File: rtl/serial_reg_master_chk.sv
module serial_reg_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             mosi,
  input logic             strobe_n,
  input logic             busy,
  input logic             done,
  input logic [DIV_W-1:0] lim
);
  logic        prev_sck;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      run      <= '0;
    end else begin
      prev_sck <= sck;
      if (sck != prev_sck) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 16'd1;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && strobe_n && !mosi));

  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  p_strobe_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> !sck);

  p_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> !sck);

  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> busy);

  p_high_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck && prev_sck) |-> (run == 16'(lim)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind serial_reg_master serial_reg_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .strobe_n(strobe_n),
  .busy(busy), .done(done), .lim(lim_q)
);

// File: tb/serial_reg_master_bench.sv
`timescale 1ns/1ps
module serial_reg_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        done, busy, sck, mosi, strobe_n;
  logic        miso = 1'b0;

  always #4 clk = ~clk;

  serial_reg_master u_serial_reg_master (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done), .busy(busy),
    .sck(sck), .mosi(mosi), .strobe_n(strobe_n), .miso(miso)
  );

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // device model
  logic [31:0] mem [256];
  logic [39:0] frm = '0, last_frm = '0;
  int          nbits = 0, last_len = 0, ncmd = 0, rd_rise = 0, rdcnt = 0;
  logic        last_cmd = 1'b0, rd_active = 1'b0, skip = 1'b0;
  logic [31:0] sout = '0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[8'h08] = 32'h0000_00C3;
    mem[8'h40] = 32'h8000_0001;
    mem[8'hFF] = 32'h0A5C_0013;
  end

  always @(sck) begin
    if (sck) begin
      if (!strobe_n) begin
        last_cmd = mosi;
        last_len = nbits;
        last_frm = frm;
        ncmd++;
        nbits = 0;
        frm = '0;
        rd_rise = 0;
        if (!mosi) begin
          sout = mem[last_frm[7:0]];
          miso = sout[31];
          rd_active = 1'b1;
          skip = 1'b1;
          rdcnt = 0;
        end else begin
          mem[last_frm[7:0]] = last_frm[39:8];
        end
      end else if (rd_active) begin
        rd_rise++;
      end else begin
        frm = {frm[38:0], mosi};
        nbits++;
      end
    end else begin
      #1;
      if (rd_active) begin
        if (skip) skip = 1'b0;
        else begin
          sout = {sout[30:0], 1'b0};
          miso = sout[31];
          rdcnt++;
          if (rdcnt == 32) begin
            rd_active = 1'b0;
            miso = 1'b0;
          end
        end
      end
    end
  end

  int hcnt = 0, last_high = 0;
  always @(negedge clk) begin
    if (sck) hcnt++;
    else if (hcnt != 0) begin
      last_high = hcnt;
      hcnt = 0;
    end
  end

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  hd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 8'h00, 32'h1234_5678, 8'd1, 32'h0},
    '{1'b0, 8'h00, 32'h0,         8'd2, 32'h1234_5678},
    '{1'b1, 8'h02, 32'hDEAD_BEEF, 8'd3, 32'h0},
    '{1'b0, 8'h02, 32'h0,         8'd1, 32'hDEAD_BEEF},
    '{1'b0, 8'h08, 32'h0,         8'd2, 32'h0000_00C3},
    '{1'b0, 8'hFF, 32'h0,         8'd0, 32'h0A5C_0013},
    '{1'b1, 8'h80, 32'h0000_0001, 8'd2, 32'h0},
    '{1'b0, 8'h80, 32'h0,         8'd1, 32'h0000_0001},
    '{1'b0, 8'h40, 32'h0,         8'd4, 32'h8000_0001}
  };

  initial begin
    bit ok;
    int c0;
    logic [31:0] prev_rd;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && strobe_n == 1'b1 && mosi == 1'b0, "R1 reset lines", {sck, strobe_n, mosi}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy after reset", busy, 1);
    wait_done(ok);
    chk(ok, "R10 boot done", ok, 1);
    chk(rdata == 32'h0A5C_0013, "R10 boot rdata", rdata, 32'h0A5C_0013);
    chk(ncmd == 1 && last_cmd == 1'b0 && last_frm[7:0] == 8'hFF, "R10 boot frame", {ncmd[7:0], last_frm[7:0]}, 16'h01FF);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 boot done width", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !sck && strobe_n && !mosi, "R1 idle lines", {busy, sck, strobe_n, mosi}, 4'b0010);

    for (int v = 0; v < 9; v++) begin
      prev_rd = rdata;
      c0 = ncmd;
      half_div = VECS[v].hd;
      wr = VECS[v].w;
      addr = VECS[v].a;
      wdata = VECS[v].d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk(ok, "R8 done seen", ok, 1);
      if (VECS[v].w) begin
        chk(last_len == 40, "R4 write bit count", last_len, 40);
        chk(last_frm == {VECS[v].d, VECS[v].a}, "R2 R4 write frame order", last_frm, {VECS[v].d, VECS[v].a});
        chk(last_cmd == 1'b1, "R4 command bit", last_cmd, 1);
        chk(rdata == prev_rd, "R4 rdata held", rdata, prev_rd);
      end else begin
        chk(last_len == 8, "R3 read bit count", last_len, 8);
        chk(last_frm[7:0] == VECS[v].a, "R2 R3 read address", last_frm[7:0], VECS[v].a);
        chk(last_cmd == 1'b0, "R3 command bit", last_cmd, 0);
        chk(rdata == VECS[v].exp, "R6 read result", rdata, VECS[v].exp);
      end
      chk(ncmd - c0 == 1, "R5 one strobe pulse", ncmd - c0, 1);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8 done width", {done, busy}, 0);
      chk(rd_rise == (VECS[v].w ? 0 : 32), "R3 R4 return clocks", rd_rise, VECS[v].w ? 0 : 32);
      chk(last_high == ((VECS[v].hd == 0) ? 1 : int'(VECS[v].hd)), "R7 high phase length",
          last_high, (VECS[v].hd == 0) ? 1 : VECS[v].hd);
      repeat (2) @(negedge clk);
    end

    // R9: start while busy
    c0 = ncmd;
    half_div = 8'd2;
    wr = 1'b0;
    addr = 8'h08;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    wr = 1'b1;
    addr = 8'h00;
    wdata = 32'hFFFF_FFFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(rdata == 32'h0000_00C3, "R9 first request result", rdata, 32'h0000_00C3);
    repeat (30) @(negedge clk);
    chk(ncmd - c0 == 1, "R9 ignored start frames", ncmd - c0, 1);
    chk(mem[8'h00] == 32'h1234_5678, "R9 register untouched", mem[8'h00], 32'h1234_5678);
    chk(!busy && !sck && strobe_n, "R1 idle after ignore", {busy, sck, strobe_n}, 3'b001);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule